// File: doc/BRIEF.md
# Mailbox Command Requester

This block is a bus master that issues a single command to a management controller through three mailbox registers: a response register, an argument register and a command register. A one-cycle `start` pulse captures a command code and a 32-bit argument. The block then performs a fixed sequence of writes on a simple valid/ready register bus. It writes zero to the response register, then the argument, then the command code. The command write is what launches the command on the far side.

After launching, the block reads the response register repeatedly. A zero value means the controller is still working. Between polls it waits a programmable interval, counted in clock cycles from a cycles-per-microsecond parameter. Polling ends on the first non-zero value, or when the retry budget is spent. In both cases the block reads the argument register once more, because the controller leaves its returned value there. It then reports the status code, the returned word and a timeout flag, and pulses `done` for one cycle.

Top module: `mbox_requester`

## Requirements
- R1: After reset, `busy`, `done`, `timeout` and `req_valid` are all low.
- R2: Each transaction begins with exactly three bus writes, in this order: 0 to the response address (`RSP_ADDR`, default 0x0), the captured argument to the argument address (`ARG_ADDR`, default 0x4), and the zero-extended command code to the command address (`CMD_ADDR`, default 0x8).
- R3: After the command write, the block issues reads of `RSP_ADDR` and continues while the value returned is 0. It stops at the first non-zero value, and that value appears on `status`.
- R4: After a poll read returns 0, the block waits exactly `POLL_US*CYC_PER_US` clock cycles after the cycle that delivers the read data, then raises the next poll request.
- R5: If `MAX_RETRY+1` poll reads all return 0, the block sets `timeout` to 1 and reports `status` 0. `timeout` is cleared when the next transaction starts.
- R6: When polling ends, whether by success or by timeout, the block performs exactly one read of `ARG_ADDR`, and the value returned appears on `ret_data`.
- R7: `done` is high for exactly one cycle. `busy` is high from the cycle after an accepted `start` through the `done` cycle, and low in the cycle after it.
- R8: A `start` pulse that arrives while `busy` is high is ignored: the transaction in flight keeps its command and argument, and no second transaction follows it.
- R9: While `req_valid` is high and `req_ready` is low, the request address, write enable and write data stay stable. A request completes only on a cycle where both are high.
- R10: `ok` is 1 exactly when `status` equals the success code 0x01. The other codes a controller may return are 0xFF (failed), 0xFE (unknown command), 0xFD (prerequisite missing) and 0xFC (controller busy), and each of them gives `ok` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that starts a transaction when idle |
| cmd_id | input | CMD_W | Command code, captured on start |
| cmd_arg | input | DATA_W | Argument word, captured on start |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Retry budget was exhausted |
| ok | output | 1 | Status equals the success code |
| status | output | DATA_W | Final response register value |
| ret_data | output | DATA_W | Argument register value read back at the end |
| req_valid | output | 1 | Bus request valid |
| req_ready | input | 1 | Bus accepts the request |
| req_addr | output | ADDR_W | Bus request address |
| req_we | output | 1 | 1 for a write, 0 for a read |
| req_wdata | output | DATA_W | Bus write data |
| rsp_valid | input | 1 | Read data valid |
| rsp_rdata | input | DATA_W | Read data |

## Verification
Every bus request is accepted at a rising edge where `req_valid` and `req_ready` are both high. The bench's responder decides the ready level at the preceding falling edge, logs the accepted request there, and returns read data one cycle later, so the latency of each read is known in advance. With ready held high, a zero poll response followed by a wait of `POLL_US*CYC_PER_US` cycles puts consecutive poll acceptances exactly that many cycles plus two apart, and the bench compares recorded acceptance times against that figure. The results, `done`, `busy` and `timeout` are sampled at falling edges. They are checked in the cycle where `done` is seen, and `done` and `busy` are checked again one cycle later.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WR_RSP,
    ST_WR_ARG,
    ST_WR_CMD,
    ST_POLL_REQ,
    ST_POLL_WAIT,
    ST_GAP,
    ST_ARG_REQ,
    ST_ARG_WAIT,
    ST_DONE
  } mbox_state_e;

  localparam logic [7:0] CODE_OK        = 8'h01;
  localparam logic [7:0] CODE_FAILED    = 8'hFF;
  localparam logic [7:0] CODE_UNKNOWN   = 8'hFE;
  localparam logic [7:0] CODE_PREREQ    = 8'hFD;
  localparam logic [7:0] CODE_REJ_BUSY  = 8'hFC;

  // Idle cycles between a zero response and the next poll request.
  function automatic int unsigned gap_cycles(input int unsigned cyc_per_us,
                                             input int unsigned poll_us);
    return cyc_per_us * poll_us;
  endfunction

  // Success test on a full-width status word.
  function automatic logic status_is_ok(input logic [31:0] s);
    return s == {24'd0, CODE_OK};
  endfunction

endpackage

// File: rtl/mbox_gap_timer.sv
module mbox_gap_timer #(
  parameter int unsigned GAP = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int unsigned CNT_W = (GAP < 2) ? 1 : $clog2(GAP);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(GAP - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= RELOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  AST_TMR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= RELOAD); // R4
  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == RELOAD)); // R4

endmodule

// File: rtl/mbox_retry_ctr.sv
module mbox_retry_ctr #(
  parameter int unsigned MAX_RETRY = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic last
);
  localparam int unsigned RTY_W = $clog2(MAX_RETRY + 2);
  localparam logic [RTY_W-1:0] LIMIT = RTY_W'(MAX_RETRY);

  logic [RTY_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (bump && (cnt != LIMIT)) begin
      cnt <= cnt + 1'b1;
    end
  end

  // The current zero read is the final allowed one.
  assign last = (cnt == LIMIT);

  AST_RTY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT); // R5

endmodule

// File: rtl/mbox_requester.sv
module mbox_requester
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned CMD_W      = 8,
  parameter int unsigned CYC_PER_US = 125,
  parameter int unsigned POLL_US    = 10,
  parameter int unsigned MAX_RETRY  = 200000,
  parameter logic [ADDR_W-1:0] RSP_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] ARG_ADDR = 'h4,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd_id,
  input  logic [DATA_W-1:0] cmd_arg,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              ok,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] ret_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_we,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata
);
  localparam int unsigned GAP = gap_cycles(CYC_PER_US, POLL_US);

  mbox_state_e state, state_nx;
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] arg_q;

  // Named internal events
  logic accept_start;
  logic req_fire;
  logic poll_data;
  logic poll_zero;
  logic poll_hit;
  logic poll_exhausted;
  logic gap_load;
  logic gap_expired;
  logic retry_last;
  logic arg_data;

  assign accept_start   = (state == ST_IDLE) && start;
  assign req_fire       = req_valid && req_ready;
  assign poll_data      = (state == ST_POLL_WAIT) && rsp_valid;
  assign poll_zero      = poll_data && (rsp_rdata == '0);
  assign poll_hit       = poll_data && (rsp_rdata != '0);
  assign poll_exhausted = poll_zero && retry_last;
  assign gap_load       = poll_zero && !retry_last;
  assign arg_data       = (state == ST_ARG_WAIT) && rsp_valid;

  mbox_gap_timer #(.GAP(GAP)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (gap_load),
    .expired (gap_expired)
  );

  mbox_retry_ctr #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept_start),
    .bump  (poll_zero),
    .last  (retry_last)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:      if (start)         state_nx = ST_WR_RSP;
      ST_WR_RSP:    if (req_fire)      state_nx = ST_WR_ARG;
      ST_WR_ARG:    if (req_fire)      state_nx = ST_WR_CMD;
      ST_WR_CMD:    if (req_fire)      state_nx = ST_POLL_REQ;
      ST_POLL_REQ:  if (req_fire)      state_nx = ST_POLL_WAIT;
      ST_POLL_WAIT: begin
        if (poll_hit || poll_exhausted) state_nx = ST_ARG_REQ;
        else if (poll_zero)             state_nx = ST_GAP;
      end
      ST_GAP:       if (gap_expired)   state_nx = ST_POLL_REQ;
      ST_ARG_REQ:   if (req_fire)      state_nx = ST_ARG_WAIT;
      ST_ARG_WAIT:  if (rsp_valid)     state_nx = ST_DONE;
      ST_DONE:                         state_nx = ST_IDLE;
      default:                         state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cmd_q    <= '0;
      arg_q    <= '0;
      status   <= '0;
      ret_data <= '0;
      timeout  <= 1'b0;
    end else begin
      state <= state_nx;
      if (accept_start) begin
        cmd_q   <= cmd_id;
        arg_q   <= cmd_arg;
        timeout <= 1'b0;
      end
      if (poll_hit) begin
        status <= rsp_rdata;
      end else if (poll_exhausted) begin
        status  <= '0;
        timeout <= 1'b1;
      end
      if (arg_data) begin
        ret_data <= rsp_rdata;
      end
    end
  end

  // Bus request generation
  always_comb begin
    req_valid = 1'b0;
    req_we    = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    unique case (state)
      ST_WR_RSP: begin
        req_valid = 1'b1;
        req_we    = 1'b1;
        req_addr  = RSP_ADDR;
      end
      ST_WR_ARG: begin
        req_valid = 1'b1;
        req_we    = 1'b1;
        req_addr  = ARG_ADDR;
        req_wdata = arg_q;
      end
      ST_WR_CMD: begin
        req_valid = 1'b1;
        req_we    = 1'b1;
        req_addr  = CMD_ADDR;
        req_wdata = {{(DATA_W-CMD_W){1'b0}}, cmd_q};
      end
      ST_POLL_REQ: begin
        req_valid = 1'b1;
        req_addr  = RSP_ADDR;
      end
      ST_ARG_REQ: begin
        req_valid = 1'b1;
        req_addr  = ARG_ADDR;
      end
      default: ;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
  assign ok   = status_is_ok(32'(status));

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid && !done); // R1
  AST_REQ_HOLD_V: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid); // R9
  AST_REQ_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> $stable(req_addr) && $stable(req_we)); // R9
  AST_REQ_HOLD_D: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> $stable(req_wdata)); // R9
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy); // R7
  AST_START_IGN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(cmd_q) && $stable(arg_q)); // R8
  AST_TMO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done && timeout |-> status == '0); // R5
  AST_HIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done && !timeout |-> status != '0); // R3

endmodule

// File: tb/sim_mbox_requester.sv
module sim_mbox_requester;
  localparam int unsigned CPU   = 2;
  localparam int unsigned PUS   = 3;
  localparam int unsigned RETRY = 3;
  localparam int unsigned GAPC  = CPU * PUS;
  localparam logic [15:0] A_RSP = 16'h0;
  localparam logic [15:0] A_ARG = 16'h4;
  localparam logic [15:0] A_CMD = 16'h8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cmd_id = '0;
  logic [31:0] cmd_arg = '0;
  logic        busy, done, timeout, ok;
  logic [31:0] status, ret_data;
  logic        req_valid, req_we;
  logic        req_ready = 1'b0;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;

  mbox_requester #(
    .CYC_PER_US(CPU), .POLL_US(PUS), .MAX_RETRY(RETRY)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_id(cmd_id), .cmd_arg(cmd_arg),
    .busy(busy), .done(done), .timeout(timeout), .ok(ok), .status(status),
    .ret_data(ret_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // Responder model state
  bit          stall = 0;
  int          polls_left = 0;
  logic [31:0] code = '0;
  logic [31:0] retval = '0;
  logic [31:0] arg_reg = '0;
  bit          pend = 0;
  logic [31:0] pend_data = '0;
  logic [15:0] wr_addr [16];
  logic [31:0] wr_data [16];
  int          wr_n = 0;
  int          poll_n = 0;
  int          arg_rd_n = 0;
  int          poll_t [16];

  always @(negedge clk) begin
    bit nr;
    cyc = cyc + 1;
    rsp_valid = 1'b0;
    if (pend) begin
      rsp_valid = 1'b1;
      rsp_rdata = pend_data;
      pend = 0;
    end
    nr = stall ? ((cyc % 3) != 0) : 1'b1;
    req_ready = nr;
    if (req_valid && nr) begin
      if (req_we) begin
        if (wr_n < 16) begin
          wr_addr[wr_n] = req_addr;
          wr_data[wr_n] = req_wdata;
        end
        wr_n = wr_n + 1;
        if (req_addr == A_ARG) arg_reg = req_wdata;
        if (req_addr == A_CMD) arg_reg = retval;
      end else begin
        pend = 1;
        if (req_addr == A_RSP) begin
          if (poll_n < 16) poll_t[poll_n] = cyc;
          poll_n = poll_n + 1;
          if (polls_left == 0) pend_data = code;
          else begin
            pend_data = '0;
            polls_left = polls_left - 1;
          end
        end else begin
          arg_rd_n = arg_rd_n + 1;
          pend_data = arg_reg;
        end
      end
    end
  end

  task automatic chk(input bit cond, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests = tests + 1;
    if (!cond) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #400000;
    tests = tests + 1;
    fails = fails + 1;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  task automatic clear_log();
    wr_n = 0; poll_n = 0; arg_rd_n = 0;
  endtask

  // Pulse start for one cycle, driven at a falling edge.
  task automatic pulse_start(input logic [7:0] c, input logic [31:0] a);
    @(negedge clk);
    cmd_id = c; cmd_arg = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  // Common checks on a finished transaction (at the done cycle).
  task automatic check_end(input logic [7:0] c, input logic [31:0] a,
                           input logic [31:0] exp_status, input bit exp_tmo,
                           input int exp_polls);
    chk(wr_n == 3, "R2 write count", 32'(wr_n), 3);
    chk(wr_addr[0] == A_RSP && wr_data[0] == 0, "R2 first write", 32'(wr_addr[0]), 32'(A_RSP));
    chk(wr_addr[1] == A_ARG && wr_data[1] == a, "R2 argument write", wr_data[1], a);
    chk(wr_addr[2] == A_CMD && wr_data[2] == {24'd0, c}, "R2 command write", wr_data[2], {24'd0, c});
    chk(poll_n == exp_polls, "R3 poll count", 32'(poll_n), 32'(exp_polls));
    chk(status == exp_status, "R3 status", status, exp_status);
    chk(timeout == exp_tmo, "R5 timeout", 32'(timeout), 32'(exp_tmo));
    chk(ret_data == retval, "R6 returned word", ret_data, retval);
    chk(arg_rd_n == 1, "R6 argument read count", 32'(arg_rd_n), 1);
    chk(ok == (exp_status == 32'h1), "R10 ok flag", 32'(ok), 32'(exp_status == 32'h1));
    chk(busy == 1'b1, "R7 busy during done", 32'(busy), 1);
    @(negedge clk);
    chk(done == 1'b0, "R7 done single cycle", 32'(done), 0);
    chk(busy == 1'b0, "R7 busy drops after done", 32'(busy), 0);
  endtask

  task automatic run_cmd(input logic [7:0] c, input logic [31:0] a,
                         input int zeros, input logic [31:0] cd,
                         input logic [31:0] rv, input bit stl);
    clear_log();
    stall = stl; polls_left = zeros; code = cd; retval = rv;
    pulse_start(c, a);
    chk(busy == 1'b1, "R7 busy after start", 32'(busy), 1);
    wait_done();
    check_end(c, a, cd, 1'b0, zeros + 1);
  endtask

  task automatic test_reset();
    chk(busy == 0, "R1 busy", 32'(busy), 0);
    chk(done == 0, "R1 done", 32'(done), 0);
    chk(timeout == 0, "R1 timeout", 32'(timeout), 0);
    chk(req_valid == 0, "R1 req_valid", 32'(req_valid), 0);
  endtask

  task automatic test_gap();
    run_cmd(8'h06, 32'h0000_0258, 2, 32'h1, 32'h0000_0255, 1'b0);
    for (int i = 0; i < 2; i++)
      chk(poll_t[i+1] - poll_t[i] == GAPC + 2, "R4 poll spacing",
          32'(poll_t[i+1] - poll_t[i]), 32'(GAPC + 2));
  endtask

  task automatic test_timeout();
    clear_log();
    stall = 0; polls_left = 1000; code = 32'h1; retval = 32'h0000_BEEF;
    pulse_start(8'h12, 32'h3);
    wait_done();
    check_end(8'h12, 32'h3, 32'h0, 1'b1, RETRY + 1);
    chk(poll_t[RETRY] - poll_t[RETRY-1] == GAPC + 2, "R4 spacing before timeout",
        32'(poll_t[RETRY] - poll_t[RETRY-1]), 32'(GAPC + 2));
  endtask

  task automatic test_start_ignored();
    clear_log();
    stall = 1; polls_left = 1; code = 32'hFD; retval = 32'h77;
    pulse_start(8'h0A, 32'hAAAA_0001);
    repeat (3) @(negedge clk);
    pulse_start(8'h0B, 32'hBBBB_0002);
    wait_done();
    check_end(8'h0A, 32'hAAAA_0001, 32'hFD, 1'b0, 2);
    repeat (20) @(negedge clk);
    chk(wr_n == 3, "R8 no second transaction", 32'(wr_n), 3);
    chk(busy == 0, "R8 idle after ignored start", 32'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    run_cmd(8'h04, 32'd600, 0, 32'h01, 32'd600, 1'b0);        // R3 immediate success
    run_cmd(8'h07, 32'd400, 2, 32'hFE, 32'd0, 1'b1);          // R9 stalled bus, unknown
    run_cmd(8'h05, 32'h1, 1, 32'hFF, 32'h5A5A_0000, 1'b1);    // R10 failed code
    run_cmd(8'h08, 32'h2, 0, 32'hFC, 32'h1, 1'b0);            // R10 busy rejection
    test_gap();
    test_timeout();
    run_cmd(8'h02, 32'h0, 0, 32'h01, 32'h0004_0100, 1'b0);    // R5 timeout cleared
    test_start_ignored();
    finish_run();
  end

endmodule